// File: doc/BRIEF.md
# Line-Code Violation Monitor

This block watches the stream of 4-bit codewords coming off a DC-balanced 3-bit-to-4-bit line code. It checks every received word, payload and control alike, against the set of words the code can legally produce given the current running disparity. Because control traffic keeps flowing even when the payload is idle, the check runs on every valid word for as long as the link is locked.

Each illegal word yields a single-cycle pulse on `viol_pulse`, which an external counter can tally. A sticky flag, `viol_sticky`, rises with the first violation and stays up until the device reset is asserted or the link drops out of lock. The input is a valid-qualified stream that is always accepted: the monitor never applies back-pressure, so there is no ready signal and a word is consumed in every cycle in which `cw_valid` is high. Only coding violations are seen. A payload error that still forms a legal codeword is not reported.

Top module: `lcv_monitor`

## Requirements
- R1: With `cw_data` written MSB first as bit 3 down to bit 0, the six weight-2 words (0011, 0101, 0110, 1001, 1010, 1100) are legal at any running disparity. 0111 and 1110 are legal only while disparity is negative. 0001 and 1000 are legal only while disparity is positive. 0000, 1111, 0010, 0100, 1011 and 1101 are always illegal.
- R2: For each checked illegal word, `viol_pulse` is high for exactly the one cycle after the clock edge that accepted the word. Back-to-back illegal words give consecutive high cycles.
- R3: `viol_sticky` rises on the same edge as the first `viol_pulse`.
- R4: While `rst_n` is high and `link_locked` is high, `viol_sticky` never falls once set, even when only legal words follow.
- R5: `rst_n` low clears `viol_pulse` and `viol_sticky` at once, without waiting for a clock edge, and sets the running disparity to negative.
- R6: At a clock edge where `link_locked` is low, `viol_sticky` is cleared. The clear takes priority over any violation.
- R7: A word is not checked when `cw_valid` is low or `link_locked` is low. Such a word produces no pulse and does not change the running disparity. While unlocked, the running disparity is held negative.
- R8: Running disparity starts negative. Each checked legal word of weight 3 or weight 1 flips it. Weight-2 words and illegal words leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| cw_valid | input | 1 | Codeword strobe. The word is always accepted. |
| cw_data | input | 4 | Received codeword, bit 3 first on the line |
| link_locked | input | 1 | High while the link is synchronised |
| viol_pulse | output | 1 | One-cycle pulse per illegal codeword |
| viol_sticky | output | 1 | Latched violation flag |

## Verification
The in-line assertions check four properties on every cycle:
- a pulse only ever follows a word that was checked;
- a pulse is always matched by the sticky flag;
- the flag holds while the link stays locked;
- an unlocked cycle always clears the flag.

The disparity rules can only be confirmed by the bench's scenarios, because they depend on the history of earlier words. These include legal alternation of the weight-1 and weight-3 words, a repeated weight-3 word that is illegal on its second use, and disparity returning to negative after a relock. The bench also covers the asynchronous reset, the fixed illegal words, and a long pseudo-random stream with occasional lock loss, comparing against a behavioural model on every clock.

// File: rtl/lcv_pkg.sv
`timescale 1ns/1ps
package lcv_pkg;
  localparam int unsigned CW_W    = 4;
  localparam int unsigned BAL_WT  = CW_W / 2;
  localparam int unsigned CNT_W   = $clog2(CW_W + 1);

  typedef logic [CW_W-1:0] cw_t;

  // Unbalanced words the code is allowed to emit.
  localparam cw_t HEAVY_A = 4'b0111;
  localparam cw_t HEAVY_B = 4'b1110;
  localparam cw_t LIGHT_A = 4'b0001;
  localparam cw_t LIGHT_B = 4'b1000;

  typedef enum logic [1:0] {
    CLS_BAL   = 2'd0,
    CLS_HEAVY = 2'd1,
    CLS_LIGHT = 2'd2,
    CLS_BAD   = 2'd3
  } cw_class_e;
endpackage

// File: rtl/lcv_classify.sv
`timescale 1ns/1ps
module lcv_classify
  import lcv_pkg::*;
(
  input  cw_t       cw,
  output cw_class_e cls
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CW_W; i++) begin
      ones = ones + CNT_W'(cw[i]);
    end
  end

  always_comb begin
    cls = CLS_BAD;
    if (ones == CNT_W'(BAL_WT)) begin
      cls = CLS_BAL;
    end else if (cw == HEAVY_A || cw == HEAVY_B) begin
      cls = CLS_HEAVY;
    end else if (cw == LIGHT_A || cw == LIGHT_B) begin
      cls = CLS_LIGHT;
    end
  end
endmodule

// File: rtl/lcv_disparity.sv
`timescale 1ns/1ps
module lcv_disparity
  import lcv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chk,
  input  logic      link_locked,
  input  cw_class_e cls,
  output logic      viol
);
  logic rd_pos;

  always_comb begin
    viol = 1'b0;
    if (chk) begin
      unique case (cls)
        CLS_BAL:   viol = 1'b0;
        CLS_HEAVY: viol = rd_pos;
        CLS_LIGHT: viol = ~rd_pos;
        CLS_BAD:   viol = 1'b1;
        default:   viol = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos <= 1'b0;
    end else if (!link_locked) begin
      rd_pos <= 1'b0;
    end else if (chk && !viol && cls != CLS_BAL) begin
      rd_pos <= ~rd_pos;
    end
  end

  AST_UNLOCK_RD_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    !link_locked |=> !rd_pos); // R7
endmodule

// File: rtl/lcv_report.sv
`timescale 1ns/1ps
module lcv_report (
  input  logic clk,
  input  logic rst_n,
  input  logic link_locked,
  input  logic viol,
  output logic viol_pulse,
  output logic viol_sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
    end else begin
      viol_pulse <= viol;
      if (!link_locked) begin
        viol_sticky <= 1'b0;
      end else if (viol) begin
        viol_sticky <= 1'b1;
      end
    end
  end

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_sticky); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sticky && link_locked) |=> viol_sticky); // R4
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !link_locked |=> !viol_sticky); // R6
endmodule

// File: rtl/lcv_monitor.sv
`timescale 1ns/1ps
module lcv_monitor
  import lcv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw_data,
  input  logic            link_locked,
  output logic            viol_pulse,
  output logic            viol_sticky
);
  cw_class_e cls;
  logic      chk;
  logic      viol;

  assign chk = cw_valid & link_locked;

  lcv_classify u_classify (
    .cw  (cw_data),
    .cls (cls)
  );

  lcv_disparity u_disparity (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk         (chk),
    .link_locked (link_locked),
    .cls         (cls),
    .viol        (viol)
  );

  lcv_report u_report (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_locked (link_locked),
    .viol        (viol),
    .viol_pulse  (viol_pulse),
    .viol_sticky (viol_sticky)
  );

  AST_PULSE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_valid && link_locked) |=> !viol_pulse); // R2
  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !link_locked |=> !viol_pulse); // R7
endmodule

// File: tb/lcv_monitor_bench.sv
`timescale 1ns/1ps
module lcv_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cw_valid = 1'b0;
  logic [3:0] cw_data = 4'd0;
  logic       link_locked = 1'b0;
  logic       viol_pulse;
  logic       viol_sticky;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R5";

  // behavioural reference state
  int m_rd = 0;   // 0 negative, 1 positive
  bit m_pulse = 0;
  bit m_sticky = 0;

  always #5 clk = ~clk;

  lcv_monitor u_lcv_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .cw_valid    (cw_valid),
    .cw_data     (cw_data),
    .link_locked (link_locked),
    .viol_pulse  (viol_pulse),
    .viol_sticky (viol_sticky)
  );

  function automatic bit is_illegal(input logic [3:0] d, input int rd);
    int w = 0;
    for (int i = 0; i < 4; i++) w += d[i];
    if (w == 2) return 0;
    if (d == 4'b0111 || d == 4'b1110) return (rd != 0);
    if (d == 4'b0001 || d == 4'b1000) return (rd == 0);
    return 1;
  endfunction

  task automatic model_edge(input logic v, input logic [3:0] d, input logic lk);
    bit bad = 0;
    if (lk && v) bad = is_illegal(d, m_rd);
    m_pulse = bad;
    if (!lk) begin
      m_sticky = 0;
      m_rd = 0;
    end else begin
      if (bad) m_sticky = 1;
      if (v && !bad && !(d == 4'b0011 || d == 4'b0101 || d == 4'b0110 ||
                         d == 4'b1001 || d == 4'b1010 || d == 4'b1100))
        m_rd = 1 - m_rd;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (viol_pulse !== m_pulse || viol_sticky !== m_sticky) begin
      n_bad++;
      $display("FAIL %s: pulse/sticky actual %b/%b expected %b/%b at %0t",
               cur_req, viol_pulse, viol_sticky, m_pulse, m_sticky, $time);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] d, input logic lk);
    cw_valid = v;
    cw_data = d;
    link_locked = lk;
    @(posedge clk);
    model_edge(v, d, lk);
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    m_rd = 0; m_pulse = 0; m_sticky = 0;
    cur_req = "R5";
    compare();
    @(negedge clk);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    @(negedge clk);
    do_reset();

    // R1: balanced words never flag
    cur_req = "R1";
    step(1, 4'b0011, 1); step(1, 4'b0101, 1); step(1, 4'b0110, 1);
    step(1, 4'b1001, 1); step(1, 4'b1010, 1); step(1, 4'b1100, 1);

    // R8: legal alternation of unbalanced words
    cur_req = "R8";
    step(1, 4'b0111, 1); step(1, 4'b0001, 1); step(1, 4'b1110, 1);
    step(1, 4'b0101, 1); step(1, 4'b1000, 1); step(1, 4'b0111, 1);

    // R8: repeated heavy word is wrong disparity; RD stays positive after it
    cur_req = "R8";
    step(1, 4'b1110, 1);
    step(1, 4'b0001, 1);

    // R4: flag holds across legal traffic and idle cycles
    cur_req = "R4";
    step(1, 4'b0011, 1); step(0, 4'b0000, 1); step(1, 4'b1100, 1);

    // R6: unlock clears flag
    cur_req = "R6";
    step(0, 4'b0000, 0);

    // R7: words while unlocked not checked
    cur_req = "R7";
    step(1, 4'b0000, 0); step(1, 4'b1111, 0); step(0, 4'b0000, 1);

    // R7: valid low ignores illegal data
    step(0, 4'b1111, 1); step(0, 4'b0010, 1);

    // R7/R8: disparity negative after relock, so light word is illegal
    cur_req = "R7";
    step(1, 4'b0001, 1);

    // R2: back-to-back fixed-illegal words give consecutive pulses
    cur_req = "R2";
    step(1, 4'b0000, 1); step(1, 4'b1111, 1); step(1, 4'b0010, 1);
    step(1, 4'b0100, 1); step(1, 4'b1011, 1); step(1, 4'b1101, 1);
    step(1, 4'b0011, 1);

    // R5: reset mid-run clears the flag asynchronously
    do_reset();
    cur_req = "R3";
    step(1, 4'b0001, 1);
    step(1, 4'b0110, 1);

    // R1: every code in both disparities, with lock dropouts
    cur_req = "R1";
    for (int k = 0; k < 600; k++) begin
      logic v, lk;
      seed = seed * 32'd1103515245 + 32'd12345;
      v  = (seed[20:18] != 3'd0);
      lk = (seed[27:23] != 5'd0);
      step(v, seed[13:10], lk);
    end

    finish_run();
  end
endmodule